// File: doc/BRIEF.md
# Level-Sensitive External Interrupt Controller

This block watches sixteen external input pins and turns their levels into interrupt requests. Each pin first passes through a two-stage synchroniser. It then passes through a per-channel debounce filter whose hold time, in millisecond ticks, software sets in that channel's control register. Software chooses for each channel whether a high or a low level is active. A channel may raise its status bit only after software has armed it with a trigger write. Software can emulate edge interrupts by inverting a channel's polarity after each event.

Software reaches the block through a simple register port. The port has a single-cycle write strobe, a byte address and 16-bit write data, and the read data is combinational. Bit n of every 16-bit status or control register belongs to channel n. A latched status bit stays set until software writes one to its clear bit. One interrupt output is the OR of all enabled status bits.

Register offsets, all 16 bits wide: 0x00 filtered pin levels (read-only), 0x04 per-channel read-visibility mask, 0x14 polarity, 0x18 interrupt enable, 0x1C raw status (read-only), 0x20 enabled status (read-only), 0x24 clear (write-only), 0x28 trigger (write-only), and 0x40 + 4*n for channel n's control register.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: While reset is asserted, and until it has been released for two clock edges, every register holds 0. Every read returns 0 and `irq` is 0.
- R2: The register offsets are those listed above. Channel n uses bit n of each 16-bit register, and channel n's control register sits at 0x40 + 4*n. An unmapped address, or an address inside the control range that is not a multiple of 4, reads 0 and ignores writes.
- R3: The pins are inputs only. Writes to 0x00, 0x1C and 0x20 change no register. Reads of 0x24 and 0x28 return 0.
- R4: With a debounce value of 0, the filtered level of a pin equals the pin value sampled three clock edges earlier (two synchroniser stages plus the filter register).
- R5: With a nonzero debounce value D, the filtered level takes the synchronised pin value only when that value has differed from the filtered level across D ms ticks in a row. A return to the filtered level, or a trigger write, restarts the count. Without a tick the filtered level cannot change.
- R6: Bit n of register 0x00 reads the filtered level of channel n ANDed with bit n of the visibility mask at 0x04.
- R7: When the polarity bit is 1, a high level is active. When it is 0, a low level is active. The raw status bit of an armed channel is set on the clock edge after its filtered level equals its active level.
- R8: Writing 1 to bit n of 0x28 arms channel n from the next cycle onward and restarts its debounce count. Writing 0 has no effect. A channel that has never been armed never sets its raw status.
- R9: Writing 1 to bit n of 0x24 clears raw status bit n on that edge, even if the level is active. The bit is set again on the following edge if the level is still active. Writing 0 has no effect.
- R10: Register 0x20 reads raw status AND interrupt enable. `irq` is 1 exactly when that value is nonzero.
- R11: Every control register is 16 bits of read/write storage. Bits [11:0] set the debounce value D, and bits [15:12] are stored and read back unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ms_tick | input | 1 | One-cycle pulse once per millisecond |
| pin_in | input | 16 | Asynchronous external channel inputs |
| wr_en | input | 1 | Single-cycle write strobe |
| addr | input | 8 | Byte address for reads and writes |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Combinational read data for `addr` |
| irq | output | 1 | Aggregated interrupt request |

## Verification
A wrong synchroniser or filter state shows up in register 0x00 within a few cycles of a pin change. It also shows up later as a raw status bit that is set or cleared on the wrong edge. A lost arm bit or clear bit shows up at 0x1C and on `irq` on the very next edge. This matters most in the clear-then-re-latch sequence, which the bench samples cycle by cycle. A debounce counter that restarts at the wrong time, or that counts clocks instead of ticks, moves the filtered level by whole tick periods. The per-clock model comparison then catches the difference at the first read of 0x00.

// File: rtl/lic_pkg.sv
package lic_pkg;
  localparam int NCH_DEF   = 16;
  localparam int DW        = 16;
  localparam int DBW       = 12;
  localparam int OFS_DATA  = 'h00;
  localparam int OFS_VIS   = 'h04;
  localparam int OFS_POL   = 'h14;
  localparam int OFS_EN    = 'h18;
  localparam int OFS_RAW   = 'h1C;
  localparam int OFS_MSK   = 'h20;
  localparam int OFS_CLR   = 'h24;
  localparam int OFS_ARM   = 'h28;
  localparam int OFS_CTL   = 'h40;
  localparam int CTL_STEP  = 4;
endpackage

// File: rtl/lic_sync.sv
module lic_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st1_q, st2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st1_q <= '0;
      st2_q <= '0;
    end else begin
      st1_q <= d;
      st2_q <= st1_q;
    end
  end

  assign q = st2_q;
endmodule

// File: rtl/lic_dbnc.sv
module lic_dbnc #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          restart,
  input  logic          din,
  input  logic [CW-1:0] limit,
  output logic          level
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          lvl_q, lvl_d;
  logic [CW:0]   cnt_inc;
  logic          hold_done;

  assign cnt_inc   = {1'b0, cnt_q} + (CW+1)'(1);
  assign hold_done = cnt_inc >= {1'b0, limit};

  always_comb begin
    cnt_d = cnt_q;
    lvl_d = lvl_q;
    if (restart) begin
      cnt_d = '0;
    end else if (limit == '0) begin
      lvl_d = din;
      cnt_d = '0;
    end else if (din == lvl_q) begin
      cnt_d = '0;
    end else if (tick) begin
      if (hold_done) begin
        lvl_d = din;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_inc[CW-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      lvl_q <= lvl_d;
    end
  end

  assign level = lvl_q;

  AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (limit != '0 && !tick) |=> $stable(level)); // R5
endmodule

// File: rtl/lic_regfile.sv
module lic_regfile #(
  parameter int NCH = 16,
  parameter int AW  = 8,
  parameter int DW  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [AW-1:0]           addr,
  input  logic [DW-1:0]           wdata,
  input  logic [NCH-1:0]          level,
  output logic [DW-1:0]           rdata,
  output logic                    irq,
  output logic [NCH-1:0]          arm_pulse,
  output logic [NCH-1:0][DW-1:0]  ctl
);
  import lic_pkg::*;

  localparam int IDXW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [AW-1:0] A_DATA = AW'(OFS_DATA);
  localparam logic [AW-1:0] A_VIS  = AW'(OFS_VIS);
  localparam logic [AW-1:0] A_POL  = AW'(OFS_POL);
  localparam logic [AW-1:0] A_EN   = AW'(OFS_EN);
  localparam logic [AW-1:0] A_RAW  = AW'(OFS_RAW);
  localparam logic [AW-1:0] A_MSK  = AW'(OFS_MSK);
  localparam logic [AW-1:0] A_CLR  = AW'(OFS_CLR);
  localparam logic [AW-1:0] A_ARM  = AW'(OFS_ARM);
  localparam logic [AW-1:0] A_CTL  = AW'(OFS_CTL);
  localparam logic [AW-1:0] CTL_SPAN = AW'(CTL_STEP * NCH);

  logic [NCH-1:0] vis_q, pol_q, en_q, raw_q, arm_q;
  logic [NCH-1:0] vis_d, pol_d, en_d, raw_d, arm_d;
  logic           vis_we, pol_we, en_we, clr_we, arm_we;
  logic [NCH-1:0] clr_mask, set_mask, hit_mask;
  logic [AW-1:0]  ctl_off;
  logic           ctl_hit;
  logic [IDXW-1:0] ctl_idx;

  // address decode
  assign vis_we  = wr_en && (addr == A_VIS);
  assign pol_we  = wr_en && (addr == A_POL);
  assign en_we   = wr_en && (addr == A_EN);
  assign clr_we  = wr_en && (addr == A_CLR);
  assign arm_we  = wr_en && (addr == A_ARM);
  assign ctl_off = addr - A_CTL;
  assign ctl_hit = (addr >= A_CTL) && (ctl_off < CTL_SPAN) && (addr[1:0] == 2'b00);
  assign ctl_idx = ctl_off[IDXW+1:2];

  assign clr_mask  = clr_we ? wdata[NCH-1:0] : '0;
  assign arm_pulse = arm_we ? wdata[NCH-1:0] : '0;
  assign hit_mask  = ~(level ^ pol_q);
  assign set_mask  = arm_q & hit_mask;

  // next state
  always_comb begin
    vis_d = vis_we ? wdata[NCH-1:0] : vis_q;
    pol_d = pol_we ? wdata[NCH-1:0] : pol_q;
    en_d  = en_we  ? wdata[NCH-1:0] : en_q;
    arm_d = arm_q | arm_pulse;
    raw_d = (raw_q | set_mask) & ~clr_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vis_q <= '0;
      pol_q <= '0;
      en_q  <= '0;
      arm_q <= '0;
      raw_q <= '0;
    end else begin
      vis_q <= vis_d;
      pol_q <= pol_d;
      en_q  <= en_d;
      arm_q <= arm_d;
      raw_q <= raw_d;
    end
  end

  // per-channel control registers, each with its own write enable
  for (genvar i = 0; i < NCH; i++) begin : g_ctl
    logic          ce;
    logic [DW-1:0] ctl_q;
    assign ce = wr_en && ctl_hit && (ctl_idx == IDXW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  ctl_q <= '0;
      else if (ce) ctl_q <= wdata;
    end
    assign ctl[i] = ctl_q;
  end

  // read path
  always_comb begin
    rdata = '0;
    if (ctl_hit) begin
      rdata = ctl[ctl_idx];
    end else begin
      case (addr)
        A_DATA:  rdata = DW'(level & vis_q);
        A_VIS:   rdata = DW'(vis_q);
        A_POL:   rdata = DW'(pol_q);
        A_EN:    rdata = DW'(en_q);
        A_RAW:   rdata = DW'(raw_q);
        A_MSK:   rdata = DW'(raw_q & en_q);
        default: rdata = '0;
      endcase
    end
  end

  assign irq = |(raw_q & en_q);

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((raw_q & $past(wdata[NCH-1:0])) == '0)); // R9
  AST_LATCH_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw_q & ~$past(raw_q) & ~$past(arm_q)) == '0)); // R8
  AST_LATCH_MATCHES_POL: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw_q & ~$past(raw_q) & ($past(level) ^ $past(pol_q))) == '0)); // R7
  AST_INPUT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == A_DATA || addr == A_RAW || addr == A_MSK))
      |=> ($stable(vis_q) && $stable(pol_q) && $stable(en_q))); // R3
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl #(
  parameter int NCH = lic_pkg::NCH_DEF,
  parameter int AW  = 8,
  parameter int DW  = lic_pkg::DW,
  parameter int DBW = lic_pkg::DBW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ms_tick,
  input  logic [NCH-1:0] pin_in,
  input  logic           wr_en,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rdata,
  output logic           irq
);
  logic [1:0]              rst_pipe_q;
  logic                    rst_int_n;
  logic [NCH-1:0]          pin_sync;
  logic [NCH-1:0]          level;
  logic [NCH-1:0]          arm_pulse;
  logic [NCH-1:0][DW-1:0]  ctl;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  lic_sync #(.W(NCH)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     (pin_in),
    .q     (pin_sync)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    lic_dbnc #(.CW(DBW)) u_dbnc (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .tick    (ms_tick),
      .restart (arm_pulse[i]),
      .din     (pin_sync[i]),
      .limit   (ctl[i][DBW-1:0]),
      .level   (level[i])
    );
  end

  lic_regfile #(.NCH(NCH), .AW(AW), .DW(DW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .level     (level),
    .rdata     (rdata),
    .irq       (irq),
    .arm_pulse (arm_pulse),
    .ctl       (ctl)
  );

  AST_IRQ_QUIET_IN_RESET: assert property (@(posedge clk)
    !rst_int_n |-> !irq); // R1
endmodule

// File: tb/lvl_irq_ctrl_bench.sv
module lvl_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ms_tick;
  logic [15:0] pin_in;
  logic        wr_en;
  logic [7:0]  addr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  lvl_irq_ctrl u_lvl_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .pin_in(pin_in),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  // behavioural reference model
  logic [15:0] m_s1, m_s2, m_flt, m_vis, m_pol, m_en, m_raw, m_arm;
  logic [15:0] m_ctl [16];
  int          m_cnt [16];
  int          rel;

  task automatic m_clear();
    m_s1 = 0; m_s2 = 0; m_flt = 0; m_vis = 0; m_pol = 0;
    m_en = 0; m_raw = 0; m_arm = 0;
    for (int i = 0; i < 16; i++) begin m_ctl[i] = 0; m_cnt[i] = 0; end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel = 0; m_clear();
    end else if (rel < 2) begin
      rel++; m_clear();
    end else begin
      logic [15:0] trg, clr, nflt;
      trg = (wr_en && addr == 8'h28) ? wdata : 16'h0;
      clr = (wr_en && addr == 8'h24) ? wdata : 16'h0;
      m_raw = (m_raw | (m_arm & ~(m_flt ^ m_pol))) & ~clr;
      nflt = m_flt;
      for (int i = 0; i < 16; i++) begin
        int lim;
        lim = m_ctl[i] & 16'h0FFF;
        if (trg[i]) m_cnt[i] = 0;
        else if (lim == 0) begin nflt[i] = m_s2[i]; m_cnt[i] = 0; end
        else if (m_s2[i] == m_flt[i]) m_cnt[i] = 0;
        else if (ms_tick) begin
          if (m_cnt[i] + 1 >= lim) begin nflt[i] = m_s2[i]; m_cnt[i] = 0; end
          else m_cnt[i]++;
        end
      end
      m_flt = nflt;
      m_s2 = m_s1; m_s1 = pin_in;
      m_arm = m_arm | trg;
      if (wr_en) begin
        if (addr == 8'h04) m_vis = wdata;
        if (addr == 8'h14) m_pol = wdata;
        if (addr == 8'h18) m_en  = wdata;
        if (addr >= 8'h40 && addr < 8'h80 && addr[1:0] == 0) m_ctl[(addr - 8'h40) >> 2] = wdata;
      end
    end
  end

  function automatic logic [15:0] mrd(logic [7:0] a);
    if (a >= 8'h40 && a < 8'h80 && a[1:0] == 0) return m_ctl[(a - 8'h40) >> 2];
    case (a)
      8'h00: return m_flt & m_vis;
      8'h04: return m_vis;
      8'h14: return m_pol;
      8'h18: return m_en;
      8'h1C: return m_raw;
      8'h20: return m_raw & m_en;
      default: return 16'h0;
    endcase
  endfunction

  function automatic string tag_of(logic [7:0] a);
    if (a >= 8'h40 && a < 8'h80 && a[1:0] == 0) return "R11";
    case (a)
      8'h00: return "R6";
      8'h1C: return "R7";
      8'h20: return "R10";
      8'h24, 8'h28: return "R3";
      default: return "R2";
    endcase
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, addr, act, exp);
    end
  endtask

  // one clock: model and DUT update at the edge, compare after the falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    #1;
    chk(tag_of(addr), rdata, mrd(addr));
    chk("R10", {15'h0, irq}, {15'h0, |(m_raw & m_en)});
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    step();
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [7:0] a, logic [15:0] exp);
    addr = a; #1;
    chk(tag, rdata, exp);
  endtask

  task automatic ticks(int n);
    for (int k = 0; k < n; k++) begin
      ms_tick = 1'b1; step(); ms_tick = 1'b0; step(); step();
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ms_tick = 0; pin_in = 16'h0; wr_en = 0; addr = 0; wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(); step();
    // R1: reset state
    rd_chk("R1", 8'h04, 16'h0);
    chk("R1", {15'h0, irq}, 16'h0);
    for (int a = 0; a < 128; a += 4) begin addr = 8'(a); step(); end
    addr = 8'h41; step();
    // R4: three-edge latency with no debounce
    wr(8'h04, 16'hFFFF);
    pin_in = 16'hA5A5; addr = 8'h00;
    step(); step();
    rd_chk("R4", 8'h00, 16'h0000);
    step();
    rd_chk("R4", 8'h00, 16'hA5A5);
    // R6: visibility mask
    wr(8'h04, 16'h0F0F);
    rd_chk("R6", 8'h00, 16'h0505);
    // R8: unarmed channels never latch
    repeat (4) step();
    rd_chk("R8", 8'h1C, 16'h0000);
    wr(8'h28, 16'hFFFF);
    addr = 8'h1C; step();
    rd_chk("R8", 8'h1C, 16'h5A5A);
    // R9: clear wins, then re-latch
    wr(8'h18, 16'hFFFF);
    wr(8'h24, 16'h0002);
    rd_chk("R9", 8'h1C, 16'h5A58);
    step();
    rd_chk("R9", 8'h1C, 16'h5A5A);
    pin_in = 16'hA5A7;
    repeat (4) step();
    wr(8'h24, 16'h0002);
    step();
    rd_chk("R9", 8'h1C, 16'h5A58);
    // R10: enable masking and irq
    wr(8'h18, 16'h0000);
    rd_chk("R10", 8'h20, 16'h0000);
    chk("R10", {15'h0, irq}, 16'h0);
    wr(8'h18, 16'h0008);
    rd_chk("R10", 8'h20, 16'h0008);
    chk("R10", {15'h0, irq}, 16'h1);
    // R7: high-active polarity latches the high channels
    wr(8'h14, 16'hFFFF);
    step(); step();
    rd_chk("R7", 8'h1C, 16'hFFFF);
    // R3: input-only, write-only registers read 0
    wr(8'h00, 16'hFFFF);
    wr(8'h20, 16'h0000);
    rd_chk("R3", 8'h00, 16'h0507);
    rd_chk("R3", 8'h18, 16'h0008);
    rd_chk("R3", 8'h24, 16'h0000);
    rd_chk("R3", 8'h28, 16'h0000);
    // R5: debounce on channel 8 with D=3
    wr(8'h04, 16'hFFFF);
    wr(8'h60, 16'h0003);
    rd_chk("R2", 8'h60, 16'h0003);
    addr = 8'h00;
    pin_in = 16'hA4A7; repeat (3) step();
    ticks(2);
    pin_in = 16'hA5A7; repeat (4) step();
    rd_chk("R5", 8'h00, 16'hA5A7);
    pin_in = 16'hA4A7; repeat (3) step();
    repeat (10) step();
    rd_chk("R5", 8'h00, 16'hA5A7);
    ticks(3);
    rd_chk("R5", 8'h00, 16'hA4A7);
    // R11: upper control bits are storage
    wr(8'h64, 16'hF003);
    rd_chk("R11", 8'h64, 16'hF003);
    // mixed traffic against the model
    for (int c = 0; c < 4000; c++) begin
      int r;
      r = $urandom_range(0, 99);
      ms_tick = (c % 5 == 0);
      if (r < 8) pin_in[$urandom_range(0, 15)] ^= 1'b1;
      if (r >= 90) begin
        logic [7:0] wa;
        case ($urandom_range(0, 6))
          0: wa = 8'h04; 1: wa = 8'h14; 2: wa = 8'h18; 3: wa = 8'h24;
          4: wa = 8'h28; 5: wa = 8'h00;
          default: wa = 8'(8'h40 + 4 * $urandom_range(0, 15));
        endcase
        addr = wa;
        wdata = 16'($urandom);
        if (wa >= 8'h40) wdata = {wdata[15:12], 10'h0, wdata[1:0]};
        wr_en = 1'b1;
      end else begin
        wr_en = 1'b0;
        addr = 8'($urandom_range(0, 33) * 4);
      end
      step();
    end
    wr_en = 0; ms_tick = 0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule